// File: doc/BRIEF.md
# Exception Qualification and Vector Unit

This block sits between a processor core's exception sources and its fetch redirect logic. Every cycle it looks at the raw requests: three reset sources, a nonmaskable-input machine-check pin, a set of internal error flags, a data-access fault report, an instruction-fetch fault report and the interrupt controller's request line. It qualifies each request against its enable bits and picks at most one winner by fixed priority. On the next clock edge it raises a one-cycle take strobe and presents that class's vector offset.

Alongside the vector, the block builds a data-fault status word from the faulting access's attributes and an instruction-fault status word from the fetch fault's attributes. Both words are latched on the same edge as the take strobe and hold until the next exception is taken. The block also drives a machine-check output pin for one cycle whenever it takes a machine check. Translation, the handlers and saving of machine state belong to other blocks.

Status bits are numbered MSB-first: status bit n sits at word position STAT_W-1-n. With the default 32-bit word, bit 1 is position 30 and bit 11 is position 20.

Top module: `exc_vector_unit`

## Requirements
- R1: A take reports offset 0x00100 for reset, 0x00200 for machine check, 0x00300 for a data storage fault, 0x00400 for an instruction storage fault and 0x00500 for an external interrupt. The vector output never shows 0x00000.
- R2: If any one of `hard_rst_req`, `soft_rst_pin` or `soft_rst_ctl` is high in a cycle, the next edge gives take=1 and vector 0x00100. No enable bit can mask a reset.
- R3: While a reset source is high, all other requests are ignored. Both status words load zero, `mc_pin_out` stays 0 and no other vector is produced.
- R4: A machine check is taken only when a check condition is present and `mc_en_hw`, `mc_en_bridge` and `ms_mc_en` are all 1. A check condition is `nmi_pin`, or some bit i with both `int_err[i]` and `int_err_en[i]` set. `mc_pin_out` is 1 exactly in the cycle a machine check is taken.
- R5: An external interrupt is taken only when `ms_ext_en` and `irq_line` are both 1.
- R6: The priority order, highest first, is reset, machine check, instruction storage fault, data storage fault, external interrupt. Exactly one class is reported per take.
- R7: `take_exc` is registered. It is 1 in the cycle after a cycle that holds a qualified request and 0 otherwise. When there is no take, `vec_off` holds its last value.
- R8: On a data fault take, status bit 1 is set when `dmiss_primary`, `dmiss_secondary` and `dmiss_block` are all 1. Bit 4 equals `dprot_viol` and bit 6 equals `dstore`.
- R9: On a data fault take, status bit 5 is set when `dext_ctl` and `dwrite_thru` are both 1, or when `ddirect_store` is 1. Bit 11 is set when `dext_ctl` is 1 and `ext_access_en` is 0. All other bits are 0.
- R10: On an instruction fault take, status bit 3 equals `idirect_store` and bit 4 equals `iprot_viol`. All other bits are 0, so a page fault leaves the word zero.
- R11: On any take, the status word of the class not taken loads zero, and a machine check or external interrupt take clears both words. Without a take, both words hold their value.
- R12: While `rst_n` is low, `take_exc` is 0, `vec_off` is 0x00100, both status words are 0 and `mc_pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| hard_rst_req | input | 1 | Hard reset request |
| soft_rst_pin | input | 1 | Soft reset pin |
| soft_rst_ctl | input | 1 | Soft reset line from the interrupt controller |
| nmi_pin | input | 1 | Machine-check condition pin |
| int_err | input | ERR_W | Internal error flags |
| int_err_en | input | ERR_W | Per-flag error enables |
| mc_en_hw | input | 1 | Implementation-level machine-check enable |
| mc_en_bridge | input | 1 | Bridge-level machine-check enable |
| ms_mc_en | input | 1 | Machine-state machine-check enable |
| ms_ext_en | input | 1 | Machine-state external-interrupt enable |
| irq_line | input | 1 | Interrupt controller request |
| ifault_req | input | 1 | Instruction-fetch fault report |
| idirect_store | input | 1 | Fetch fault hit a direct-store segment |
| iprot_viol | input | 1 | Fetch fault was a protection violation |
| dfault_req | input | 1 | Data-access fault report |
| dmiss_primary | input | 1 | No translation in the primary hash group |
| dmiss_secondary | input | 1 | No translation in the secondary hash group |
| dmiss_block | input | 1 | No match in a data block-address range |
| dprot_viol | input | 1 | Data access protection violation |
| dstore | input | 1 | Faulting access was a store |
| dext_ctl | input | 1 | Faulting access was an external-control access |
| dwrite_thru | input | 1 | Target address is write-through |
| ddirect_store | input | 1 | Load/store to a direct-store segment |
| ext_access_en | input | 1 | External-control access enable |
| take_exc | output | 1 | One-cycle take strobe |
| vec_off | output | VEC_W | Vector offset of the taken exception |
| mc_pin_out | output | 1 | Machine-check output pin |
| dstat | output | STAT_W | Data-fault status word |
| istat | output | STAT_W | Instruction-fault status word |

## Verification
The hardest situation to reach from the ports is a fully qualified machine check that also competes with a reset, a fetch fault, a data fault and an enabled interrupt in the same cycle. Reaching it needs every enable bit lined up at once, so random stimulus seldom gets there. The bench sweeps all combinations of the reset sources, the check condition, the three enables, the fault reports and the interrupt qualifiers, which includes every such collision. A separate sweep walks all 512 data-fault attribute patterns and all fetch-fault patterns to cover the status encoding.

// File: rtl/exc_vector_unit.sv
`timescale 1ns/1ps
module exc_vector_unit #(
  parameter int ERR_W  = 4,
  parameter int VEC_W  = 20,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_rst_req,
  input  logic              soft_rst_pin,
  input  logic              soft_rst_ctl,
  input  logic              nmi_pin,
  input  logic [ERR_W-1:0]  int_err,
  input  logic [ERR_W-1:0]  int_err_en,
  input  logic              mc_en_hw,
  input  logic              mc_en_bridge,
  input  logic              ms_mc_en,
  input  logic              ms_ext_en,
  input  logic              irq_line,
  input  logic              ifault_req,
  input  logic              idirect_store,
  input  logic              iprot_viol,
  input  logic              dfault_req,
  input  logic              dmiss_primary,
  input  logic              dmiss_secondary,
  input  logic              dmiss_block,
  input  logic              dprot_viol,
  input  logic              dstore,
  input  logic              dext_ctl,
  input  logic              dwrite_thru,
  input  logic              ddirect_store,
  input  logic              ext_access_en,
  output logic              take_exc,
  output logic [VEC_W-1:0]  vec_off,
  output logic              mc_pin_out,
  output logic [STAT_W-1:0] dstat,
  output logic [STAT_W-1:0] istat
);

  localparam logic [VEC_W-1:0] VEC_RST = VEC_W'('h100);
  localparam logic [VEC_W-1:0] VEC_MC  = VEC_W'('h200);
  localparam logic [VEC_W-1:0] VEC_DSF = VEC_W'('h300);
  localparam logic [VEC_W-1:0] VEC_ISF = VEC_W'('h400);
  localparam logic [VEC_W-1:0] VEC_EXT = VEC_W'('h500);

  localparam int D_MISS  = STAT_W - 1 - 1;
  localparam int D_PROT  = STAT_W - 1 - 4;
  localparam int D_ATTR  = STAT_W - 1 - 5;
  localparam int D_STORE = STAT_W - 1 - 6;
  localparam int D_EAEN  = STAT_W - 1 - 11;
  localparam int I_DSEG  = STAT_W - 1 - 3;
  localparam int I_PROT  = STAT_W - 1 - 4;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_RST, CLS_MC, CLS_ISF, CLS_DSF, CLS_EXT
  } cls_t;

  logic rst_any, mc_cond, mc_q, ext_q;
  cls_t cls;
  logic [STAT_W-1:0] dstat_nx, istat_nx;

  assign rst_any = hard_rst_req | soft_rst_pin | soft_rst_ctl;
  assign mc_cond = nmi_pin | (|(int_err & int_err_en));
  assign mc_q    = mc_cond & mc_en_hw & mc_en_bridge & ms_mc_en;
  assign ext_q   = ms_ext_en & irq_line;

  always_comb begin
    if (rst_any)         cls = CLS_RST;
    else if (mc_q)       cls = CLS_MC;
    else if (ifault_req) cls = CLS_ISF;
    else if (dfault_req) cls = CLS_DSF;
    else if (ext_q)      cls = CLS_EXT;
    else                 cls = CLS_NONE;
  end

  always_comb begin
    dstat_nx          = '0;
    dstat_nx[D_MISS]  = dmiss_primary & dmiss_secondary & dmiss_block;
    dstat_nx[D_PROT]  = dprot_viol;
    dstat_nx[D_ATTR]  = (dext_ctl & dwrite_thru) | ddirect_store;
    dstat_nx[D_STORE] = dstore;
    dstat_nx[D_EAEN]  = dext_ctl & ~ext_access_en;
    istat_nx          = '0;
    istat_nx[I_DSEG]  = idirect_store;
    istat_nx[I_PROT]  = iprot_viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_exc   <= 1'b0;
      vec_off    <= VEC_RST;
      mc_pin_out <= 1'b0;
      dstat      <= '0;
      istat      <= '0;
    end else begin
      take_exc   <= (cls != CLS_NONE);
      mc_pin_out <= (cls == CLS_MC);
      if (cls != CLS_NONE) begin
        dstat <= (cls == CLS_DSF) ? dstat_nx : '0;
        istat <= (cls == CLS_ISF) ? istat_nx : '0;
        unique case (cls)
          CLS_RST: vec_off <= VEC_RST;
          CLS_MC:  vec_off <= VEC_MC;
          CLS_ISF: vec_off <= VEC_ISF;
          CLS_DSF: vec_off <= VEC_DSF;
          default: vec_off <= VEC_EXT;
        endcase
      end
    end
  end

endmodule

// File: rtl/exc_vector_unit_chk.sv
`timescale 1ns/1ps
module exc_vector_unit_chk #(
  parameter int ERR_W  = 4,
  parameter int VEC_W  = 20,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hard_rst_req,
  input logic              soft_rst_pin,
  input logic              soft_rst_ctl,
  input logic              mc_en_hw,
  input logic              mc_en_bridge,
  input logic              ms_mc_en,
  input logic              ms_ext_en,
  input logic              irq_line,
  input logic              take_exc,
  input logic [VEC_W-1:0]  vec_off,
  input logic              mc_pin_out,
  input logic [STAT_W-1:0] dstat,
  input logic [STAT_W-1:0] istat
);

  logic rst_in;
  assign rst_in = hard_rst_req | soft_rst_pin | soft_rst_ctl;

  AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    vec_off != '0); // R1

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> (vec_off == VEC_W'('h100) || vec_off == VEC_W'('h200) ||
                  vec_off == VEC_W'('h300) || vec_off == VEC_W'('h400) ||
                  vec_off == VEC_W'('h500))); // R1

  AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_in |=> (take_exc && vec_off == VEC_W'('h100) && dstat == '0 &&
                istat == '0 && !mc_pin_out)); // R3

  AST_MC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mc_pin_out |-> $past(mc_en_hw && mc_en_bridge && ms_mc_en)); // R4

  AST_MC_PIN_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    mc_pin_out |-> (take_exc && vec_off == VEC_W'('h200))); // R4

  AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && vec_off == VEC_W'('h500)) |-> $past(ms_ext_en && irq_line)); // R5

  AST_DSTAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |-> $stable(dstat)); // R11

  AST_ISTAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |-> $stable(istat)); // R11

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |-> $stable(vec_off)); // R7

endmodule

bind exc_vector_unit exc_vector_unit_chk #(
  .ERR_W(ERR_W), .VEC_W(VEC_W), .STAT_W(STAT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .hard_rst_req(hard_rst_req), .soft_rst_pin(soft_rst_pin), .soft_rst_ctl(soft_rst_ctl),
  .mc_en_hw(mc_en_hw), .mc_en_bridge(mc_en_bridge), .ms_mc_en(ms_mc_en),
  .ms_ext_en(ms_ext_en), .irq_line(irq_line),
  .take_exc(take_exc), .vec_off(vec_off), .mc_pin_out(mc_pin_out),
  .dstat(dstat), .istat(istat)
);

// File: tb/exc_vector_unit_tb_top.sv
`timescale 1ns/1ps
module exc_vector_unit_tb_top;
  localparam int ERR_W = 4, VEC_W = 20, STAT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hard_rst_req, soft_rst_pin, soft_rst_ctl, nmi_pin;
  logic [ERR_W-1:0] int_err, int_err_en;
  logic mc_en_hw, mc_en_bridge, ms_mc_en, ms_ext_en, irq_line;
  logic ifault_req, idirect_store, iprot_viol;
  logic dfault_req, dmiss_primary, dmiss_secondary, dmiss_block, dprot_viol;
  logic dstore, dext_ctl, dwrite_thru, ddirect_store, ext_access_en;
  logic take_exc, mc_pin_out;
  logic [VEC_W-1:0] vec_off;
  logic [STAT_W-1:0] dstat, istat;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [VEC_W-1:0]  e_vec;
  logic [STAT_W-1:0] e_d, e_i;

  always #4 clk = ~clk;

  exc_vector_unit #(.ERR_W(ERR_W), .VEC_W(VEC_W), .STAT_W(STAT_W)) dut_i (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [STAT_W-1:0] sb(input int n);
    return STAT_W'(1) << (STAT_W - 1 - n);
  endfunction

  task automatic clear_inputs();
    {hard_rst_req, soft_rst_pin, soft_rst_ctl, nmi_pin} = '0;
    int_err = '0; int_err_en = '0;
    {mc_en_hw, mc_en_bridge, ms_mc_en, ms_ext_en, irq_line} = '0;
    {ifault_req, idirect_store, iprot_viol} = '0;
    {dfault_req, dmiss_primary, dmiss_secondary, dmiss_block, dprot_viol} = '0;
    {dstore, dext_ctl, dwrite_thru, ddirect_store, ext_access_en} = '0;
  endtask

  // inputs already driven; predict, wait for edge, compare
  task automatic step();
    logic r, m, x;
    int k;
    logic [STAT_W-1:0] dn, inn;
    string tag;
    r = hard_rst_req | soft_rst_pin | soft_rst_ctl;
    m = (nmi_pin | (|(int_err & int_err_en))) & mc_en_hw & mc_en_bridge & ms_mc_en;
    x = ms_ext_en & irq_line;
    dn = ((dmiss_primary & dmiss_secondary & dmiss_block) ? sb(1) : '0)
       | (dprot_viol ? sb(4) : '0)
       | (((dext_ctl & dwrite_thru) | ddirect_store) ? sb(5) : '0)
       | (dstore ? sb(6) : '0)
       | ((dext_ctl & ~ext_access_en) ? sb(11) : '0);
    inn = (idirect_store ? sb(3) : '0) | (iprot_viol ? sb(4) : '0);
    if (r)               begin k = 1; tag = "R2"; end
    else if (m)          begin k = 2; tag = "R4"; end
    else if (ifault_req) begin k = 4; tag = "R6"; end
    else if (dfault_req) begin k = 3; tag = "R6"; end
    else if (x)          begin k = 5; tag = "R5"; end
    else                 begin k = 0; tag = "R7"; end
    @(posedge clk); #1;
    if (k != 0) begin
      e_vec = VEC_W'(k * 'h100);
      e_d = (k == 3) ? dn : '0;
      e_i = (k == 4) ? inn : '0;
    end
    chk(tag, 32'(take_exc), 32'(k != 0));
    chk("R1", 32'(vec_off), 32'(e_vec));
    chk("R4", 32'(mc_pin_out), 32'(k == 2));
    chk(r ? "R3" : "R11", dstat, e_d);
    chk(r ? "R3" : "R11", istat, e_i);
    if (k == 3) begin
      chk("R8", dstat & (sb(1)|sb(4)|sb(6)), dn & (sb(1)|sb(4)|sb(6)));
      chk("R9", dstat & ~(sb(1)|sb(4)|sb(6)), dn & ~(sb(1)|sb(4)|sb(6)));
    end
    if (k == 4) chk("R10", istat, inn);
  endtask

  initial begin
    clear_inputs();
    e_vec = VEC_W'('h100); e_d = '0; e_i = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12", 32'(take_exc), 0);
    chk("R12", 32'(vec_off), 32'h100);
    chk("R12", dstat, 0);
    chk("R12", istat, 0);
    chk("R12", 32'(mc_pin_out), 0);
    @(negedge clk); rst_n = 1'b1;

    // full sweep of request and qualifier combinations
    for (int v = 0; v < 8192; v++) begin
      logic [8:0] dd;
      @(negedge clk);
      dd = 9'(v ^ (v >> 4) ^ (v >> 9));
      {soft_rst_ctl, soft_rst_pin, hard_rst_req} = v[2:0];
      nmi_pin = v[3];
      int_err = {ERR_W{1'b0}} | ERR_W'(v[4]) << (v % ERR_W);
      int_err_en = {ERR_W{1'b0}} | ERR_W'(v[5]) << (v % ERR_W);
      {mc_en_hw, mc_en_bridge, ms_mc_en, ms_ext_en} = v[9:6];
      ifault_req = v[10]; dfault_req = v[11]; irq_line = v[12];
      {idirect_store, iprot_viol} = dd[1:0];
      {dmiss_primary, dmiss_secondary, dmiss_block, dprot_viol, dstore,
       dext_ctl, dwrite_thru, ddirect_store, ext_access_en} = dd;
      step();
    end

    // every data-fault attribute pattern, each followed by an idle hold cycle
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      clear_inputs();
      dfault_req = 1'b1;
      {dmiss_primary, dmiss_secondary, dmiss_block, dprot_viol, dstore,
       dext_ctl, dwrite_thru, ddirect_store, ext_access_en} = 9'(a);
      step();
      @(negedge clk);
      clear_inputs();
      irq_line = 1'b1;
      step();
    end

    // fetch-fault patterns, including page fault with neither bit
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      clear_inputs();
      ifault_req = 1'b1;
      {idirect_store, iprot_viol} = 2'(b);
      dfault_req = 1'b1; dstore = 1'b1;
      step();
      @(negedge clk);
      clear_inputs();
      step();
    end

    // reset during a pending external interrupt and a fault
    @(negedge clk);
    clear_inputs();
    dfault_req = 1'b1; dprot_viol = 1'b1;
    step();
    @(negedge clk);
    soft_rst_pin = 1'b1; ms_ext_en = 1'b1; irq_line = 1'b1;
    step();

    @(negedge clk);
    clear_inputs();
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule